// File: doc/BRIEF.md
# USB line-state and bus-event classifier

This block watches the two USB data lines on an oversampling clock and reports, every sample, which line symbol is present: single-ended zero, J, K or single-ended one. Which of the two differential pairings counts as J depends on the current speed mode. Full speed and low speed have opposite J/K polarity. A third mode uses the low-speed bit rate with full-speed polarity, and a packet decoder downstream can request that mode once it has seen a preamble.

The speed mode comes either from a configuration input, which forces full or low speed, or from automatic detection. In automatic detection the idle level of the line picks the speed: D+ high means full speed and D- high means low speed. The block also times every single-ended-zero period and judges its length when the period ends. A long period is a bus reset, which puts the speed mode back to the configured setting. A medium period seen while in low-speed mode is a keep-alive. Each event gives a one-cycle pulse. Decoding packet bits and recovering the bit clock belong to other blocks.

Top module: `usb_line_classifier`

## Requirements
- R1: In every speed mode, both lines low give symbol code 0 (single-ended zero) and both lines high give symbol code 3 (single-ended one).
- R2: In full-speed mode (speed_mode 0), D+ high with D- low gives code 1 (J) and D+ low with D- high gives code 2 (K). The code changes on the third rising clock edge after the input changes.
- R3: In low-speed mode (speed_mode 1), J and K are swapped: D+ low with D- high gives code 1 and D+ high with D- low gives code 2.
- R4: A one-cycle pulse on pre_req selects mode 2 (low rate, full-speed polarity), which maps the line pairs as in R2. speed_mode never takes the value 3.
- R5: With cfg_mode 0 (automatic), the speed mode is learned from the first valid sample after reset, and again at the end of every single-ended-zero period that lasted at least 2 samples. A D+-high level gives mode 0, a D--high level gives mode 1, and a both-high level leaves the mode unchanged.
- R6: A single-ended-zero period longer than 120 samples gives a one-cycle bus_reset pulse when it ends. The speed mode then goes to the configured setting: mode 1 for cfg_mode 2, otherwise mode 0, followed by R5 learning when the mode is automatic.
- R7: In mode 1 only, a single-ended-zero period longer than 57 samples and at most 120 samples gives a one-cycle keep_alive pulse when it ends. A period of 57 samples or fewer gives no pulse, and so does any period in mode 0 or mode 2.
- R8: With cfg_mode 1 (force full) or 2 (force low), the line level is never used to learn the speed. A single-ended-zero period that is not a reset leaves the speed mode unchanged.
- R9: During reset, sym_code reads 1 (idle J) and both event pulses are low. Reset is synchronous and active low.
- R10: bus_reset and keep_alive are never high together, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock (48 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| dp_in | input | 1 | Raw D+ line, asynchronous |
| dm_in | input | 1 | Raw D- line, asynchronous |
| cfg_mode | input | 2 | 0 automatic, 1 force full speed, 2 force low speed, 3 treated as automatic |
| pre_req | input | 1 | One-cycle request for low-rate full-polarity mode |
| sym_code | output | 2 | 0 SE0, 1 J, 2 K, 3 SE1 |
| speed_mode | output | 2 | 0 full, 1 low, 2 low rate with full polarity |
| bus_reset | output | 1 | One-cycle pulse at the end of a reset-length SE0 |
| keep_alive | output | 1 | One-cycle pulse at the end of a keep-alive-length SE0 |

## Verification
The bench builds the block with its default thresholds of 120 and 57 samples, so both boundaries fall within a few hundred cycles. It drives single-ended-zero periods of exactly 57, 58, 120, 121 and 200 samples to reach both edges of the keep-alive window and the reset boundary. The block is reset with each of the three configuration values, which covers automatic learning at both speeds as well as the forced modes. Preamble-mode entry and its return to the configured speed on a bus reset are reached under forced low speed.

// File: rtl/usb_lc_pkg.sv
// Shared encodings for the USB line-state classifier.
// Assumes: codes are visible at the top ports as plain 2-bit values.
package usb_lc_pkg;
    typedef enum logic [1:0] {
        SYM_SE0 = 2'd0,
        SYM_J   = 2'd1,
        SYM_K   = 2'd2,
        SYM_SE1 = 2'd3
    } sym_t;

    typedef enum logic [1:0] {
        SPD_FULL    = 2'd0,
        SPD_LOW     = 2'd1,
        SPD_LR_FPOL = 2'd2
    } spd_t;

    localparam logic [1:0] CFG_FULL = 2'd1;
    localparam logic [1:0] CFG_LOW  = 2'd2;
endpackage

// File: rtl/usb_lc_sync.sv
// Multi-flop synchronizer for a bundle of asynchronous lines.
// Assumes: each line is quasi-static for more than one sample; the bits are
// synchronized independently, so skew between them is handled downstream.
module usb_lc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0] chain [WIDTH];

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        // Shift the raw line through the synchronizer stages.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[b] <= '0;
            else        chain[b] <= {chain[b][STAGES-2:0], async_in[b]};
        end
        assign sync_out[b] = chain[b][STAGES-1];
    end
endmodule

// File: rtl/usb_lc_se0_timer.sv
// Times single-ended-zero periods and classifies them when they end.
// Assumes: dp/dm are synchronized; line_valid marks samples worth counting.
// The count saturates just above the reset threshold.
module usb_lc_se0_timer
    import usb_lc_pkg::*;
#(
    parameter int RESET_CYC = 120,
    parameter int KA_CYC    = 57,
    parameter int LEARN_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_valid,
    input  logic       dp,
    input  logic       dm,
    input  logic [1:0] cur_mode,
    output logic       se0_end,
    output logic       end_is_reset,
    output logic       end_learn_ok,
    output logic       bus_reset,
    output logic       keep_alive
);
    localparam int SAT   = RESET_CYC + 1;
    localparam int CNT_W = $clog2(SAT + 1);
    localparam logic [CNT_W-1:0] SAT_V   = CNT_W'(SAT);
    localparam logic [CNT_W-1:0] RST_V   = CNT_W'(RESET_CYC);
    localparam logic [CNT_W-1:0] KA_V    = CNT_W'(KA_CYC);
    localparam logic [CNT_W-1:0] LEARN_V = CNT_W'(LEARN_CYC);

    logic [CNT_W-1:0] cnt;
    logic             line_se0;
    logic             ka_window;

    // Decode the current sample and the end-of-period classes.
    always_comb begin
        line_se0     = line_valid && !dp && !dm;
        se0_end      = line_valid && !line_se0 && (cnt != '0);
        end_is_reset = se0_end && (cnt > RST_V);
        end_learn_ok = se0_end && (cnt >= LEARN_V);
        ka_window    = (cnt > KA_V) && (cnt <= RST_V);
    end

    // Count SE0 samples and issue the one-cycle event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            bus_reset  <= 1'b0;
            keep_alive <= 1'b0;
        end else begin
            bus_reset  <= end_is_reset;
            keep_alive <= se0_end && ka_window && (cur_mode == SPD_LOW);
            if (!line_se0)       cnt <= '0;
            else if (cnt != SAT_V) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/usb_lc_speed_ctl.sv
// Holds the speed mode: forced by configuration, learned from the idle level,
// restored on bus reset, and switched to low-rate full-polarity on request.
// Assumes: cfg_mode changes only while rst_n is low.
module usb_lc_speed_ctl
    import usb_lc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_mode,
    input  logic       first_sample,
    input  logic       dp,
    input  logic       dm,
    input  logic       se0_end,
    input  logic       end_is_reset,
    input  logic       end_learn_ok,
    input  logic       pre_req,
    output logic [1:0] mode
);
    logic       is_auto;
    logic [1:0] cfg_default;
    logic [1:0] learned;
    logic [1:0] mode_nx;

    // Work out the configured default and the level-learned speed.
    always_comb begin
        is_auto     = (cfg_mode != CFG_FULL) && (cfg_mode != CFG_LOW);
        cfg_default = (cfg_mode == CFG_LOW) ? SPD_LOW : SPD_FULL;
        learned     = mode;
        if (dp && !dm)      learned = SPD_FULL;
        else if (!dp && dm) learned = SPD_LOW;
    end

    // Choose the next mode; a preamble request wins over everything else.
    always_comb begin
        mode_nx = mode;
        if (first_sample && is_auto) mode_nx = learned;
        if (se0_end) begin
            if (end_is_reset) mode_nx = cfg_default;
            if (is_auto && end_learn_ok) begin
                if (dp != dm) mode_nx = learned;
            end
        end
        if (pre_req) mode_nx = SPD_LR_FPOL;
    end

    // Register the speed mode.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= cfg_default;
        else        mode <= mode_nx;
    end
endmodule

// File: rtl/usb_lc_symbol.sv
// Maps the synchronized line pair to a registered symbol code using the
// polarity of the current speed mode.
// Assumes: output holds idle J until the synchronizer carries valid samples.
module usb_lc_symbol
    import usb_lc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_valid,
    input  logic       dp,
    input  logic       dm,
    input  logic [1:0] mode,
    output logic [1:0] sym
);
    logic       low_pol;
    logic [1:0] sym_nx;

    // Pick the symbol for the present sample.
    always_comb begin
        low_pol = (mode == SPD_LOW);
        case ({dp, dm})
            2'b00:   sym_nx = SYM_SE0;
            2'b11:   sym_nx = SYM_SE1;
            2'b10:   sym_nx = low_pol ? SYM_K : SYM_J;
            default: sym_nx = low_pol ? SYM_J : SYM_K;
        endcase
    end

    // Register the symbol code.
    always_ff @(posedge clk) begin
        if (!rst_n)          sym <= SYM_J;
        else if (line_valid) sym <= sym_nx;
    end
endmodule

// File: rtl/usb_line_classifier.sv
// USB line-state and bus-event classifier top level.
// Assumes: clk oversamples the line (48 MHz for the default thresholds);
// dp_in/dm_in are asynchronous; cfg_mode is static outside reset.
module usb_line_classifier
    import usb_lc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RESET_CYC   = 120,
    parameter int KA_CYC      = 57,
    parameter int LEARN_CYC   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dp_in,
    input  logic       dm_in,
    input  logic [1:0] cfg_mode,
    input  logic       pre_req,
    output logic [1:0] sym_code,
    output logic [1:0] speed_mode,
    output logic       bus_reset,
    output logic       keep_alive
);
    localparam int FILL_W = $clog2(SYNC_STAGES + 2);
    localparam logic [FILL_W-1:0] FILL_DONE = FILL_W'(SYNC_STAGES);

    logic [1:0]        lines;
    logic [FILL_W-1:0] fill;
    logic              line_valid;
    logic              first_sample;
    logic              se0_end;
    logic              end_is_reset;
    logic              end_learn_ok;

    usb_lc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in({dp_in, dm_in}), .sync_out(lines)
    );

    // Track when the synchronizer has been filled after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)              fill <= '0;
        else if (fill <= FILL_DONE) fill <= fill + 1'b1;
    end
    assign line_valid   = (fill >= FILL_DONE);
    assign first_sample = (fill == FILL_DONE);

    usb_lc_se0_timer #(.RESET_CYC(RESET_CYC), .KA_CYC(KA_CYC), .LEARN_CYC(LEARN_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .line_valid(line_valid),
        .dp(lines[1]), .dm(lines[0]), .cur_mode(speed_mode),
        .se0_end(se0_end), .end_is_reset(end_is_reset), .end_learn_ok(end_learn_ok),
        .bus_reset(bus_reset), .keep_alive(keep_alive)
    );

    usb_lc_speed_ctl u_speed (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .first_sample(first_sample),
        .dp(lines[1]), .dm(lines[0]), .se0_end(se0_end), .end_is_reset(end_is_reset),
        .end_learn_ok(end_learn_ok), .pre_req(pre_req), .mode(speed_mode)
    );

    usb_lc_symbol u_sym (
        .clk(clk), .rst_n(rst_n), .line_valid(line_valid),
        .dp(lines[1]), .dm(lines[0]), .mode(speed_mode), .sym(sym_code)
    );
endmodule

// File: rtl/usb_lc_checker.sv
// Port-level property checker for the USB line-state classifier.
module usb_lc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_mode,
    input logic       pre_req,
    input logic [1:0] speed_mode,
    input logic       bus_reset,
    input logic       keep_alive
);
    // R10: event pulses are mutually exclusive
    a_r10_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_reset && keep_alive));

    // R10: bus reset pulse lasts one cycle
    a_r10_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !bus_reset);

    // R10: keep-alive pulse lasts one cycle
    a_r10_ka_single: assert property (@(posedge clk) disable iff (!rst_n)
        keep_alive |=> !keep_alive);

    // R7: keep-alive only comes from low-speed mode
    a_r7_ka_low_only: assert property (@(posedge clk) disable iff (!rst_n)
        keep_alive |-> ($past(speed_mode) == 2'd1));

    // R4: speed mode stays within its legal values
    a_r4_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        speed_mode != 2'd3);

    // R6: a bus reset under forced low speed lands in low-speed mode
    a_r6_reset_to_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && $past(cfg_mode) == 2'd2 && !$past(pre_req)) |-> (speed_mode == 2'd1));

    // R8: under forced low speed, low mode is left only by a preamble request
    a_r8_forced_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_mode) == 2'd2 && $past(speed_mode) == 2'd1 && !$past(pre_req))
        |-> (speed_mode == 2'd1));
endmodule

bind usb_line_classifier usb_lc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .pre_req(pre_req),
    .speed_mode(speed_mode), .bus_reset(bus_reset), .keep_alive(keep_alive)
);

// File: tb/sim_usb_line_classifier.sv
module sim_usb_line_classifier;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dp_in = 1'b1;
    logic       dm_in = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic       pre_req = 1'b0;
    logic [1:0] sym_code;
    logic [1:0] speed_mode;
    logic       bus_reset;
    logic       keep_alive;

    int total = 0;
    int bad = 0;
    int n_rst = 0;
    int n_ka = 0;

    always #2.5 clk = ~clk;

    usb_line_classifier u0 (
        .clk(clk), .rst_n(rst_n), .dp_in(dp_in), .dm_in(dm_in),
        .cfg_mode(cfg_mode), .pre_req(pre_req), .sym_code(sym_code),
        .speed_mode(speed_mode), .bus_reset(bus_reset), .keep_alive(keep_alive)
    );

    // Count event pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n && bus_reset)  n_rst++;
        if (rst_n && keep_alive) n_ka++;
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic p, input logic m);
        dp_in = p;
        dm_in = m;
    endtask

    task automatic start(input logic [1:0] cfg, input logic p, input logic m);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_mode = cfg;
        drive(p, m);
        wait_n(4);
        check("R9 reset sym", sym_code, 1);
        check("R9 reset pulses", {bus_reset, keep_alive}, 0);
        rst_n = 1'b1;
        wait_n(8);
    endtask

    // SE0 of len samples, then the given idle level.
    task automatic se0(input int len, input logic p, input logic m);
        drive(1'b0, 1'b0);
        wait_n(len);
        drive(p, m);
        wait_n(8);
    endtask

    task automatic t_auto_full();
        start(2'd0, 1'b1, 1'b0);
        check("R5 auto learn full", speed_mode, 0);
        check("R2 J", sym_code, 1);
        drive(1'b0, 1'b1);
        wait_n(2);
        check("R2 latency old", sym_code, 1);
        wait_n(1);
        check("R2 K at third edge", sym_code, 2);
        drive(1'b0, 1'b0);
        wait_n(5);
        check("R1 SE0 full", sym_code, 0);
        drive(1'b1, 1'b1);
        wait_n(5);
        check("R1 SE1 full", sym_code, 3);
        check("R5 SE1 keeps mode", speed_mode, 0);
        drive(1'b1, 1'b0);
        wait_n(5);
        begin
            int k0 = n_ka;
            int r0 = n_rst;
            se0(80, 1'b1, 1'b0);
            check("R7 no keep-alive at full", n_ka - k0, 0);
            check("R7 no reset at 80", n_rst - r0, 0);
        end
    endtask

    task automatic t_auto_low();
        start(2'd0, 1'b0, 1'b1);
        check("R5 auto learn low", speed_mode, 1);
        check("R3 J low", sym_code, 1);
        drive(1'b1, 1'b0);
        wait_n(5);
        check("R3 K low", sym_code, 2);
        drive(1'b0, 1'b0);
        wait_n(5);
        check("R1 SE0 low", sym_code, 0);
        drive(1'b0, 1'b1);
        wait_n(5);
    endtask

    task automatic ka_case(input int len, input int exp_ka, input int exp_rst);
        int k0 = n_ka;
        int r0 = n_rst;
        se0(len, 1'b0, 1'b1);
        check($sformatf("R7 keep-alive len %0d", len), n_ka - k0, exp_ka);
        check($sformatf("R6 reset len %0d", len), n_rst - r0, exp_rst);
        check("R5 stays low", speed_mode, 1);
    endtask

    task automatic t_keepalive();
        ka_case(57, 0, 0);
        ka_case(58, 1, 0);
        ka_case(120, 1, 0);
        ka_case(121, 0, 1);
    endtask

    task automatic t_reset_relearn();
        int r0 = n_rst;
        se0(200, 1'b1, 1'b0);
        check("R6 reset pulse", n_rst - r0, 1);
        check("R5 relearn full after reset", speed_mode, 0);
        check("R2 J after relearn", sym_code, 1);
    endtask

    task automatic t_forced_low();
        start(2'd2, 1'b1, 1'b0);
        check("R8 forced low ignores level", speed_mode, 1);
        check("R3 K forced low", sym_code, 2);
        se0(10, 1'b1, 1'b0);
        check("R8 short SE0 keeps mode", speed_mode, 1);
        pre_req = 1'b1;
        @(negedge clk);
        pre_req = 1'b0;
        wait_n(4);
        check("R4 preamble mode", speed_mode, 2);
        check("R4 full polarity J", sym_code, 1);
        drive(1'b0, 1'b1);
        wait_n(5);
        check("R4 full polarity K", sym_code, 2);
        drive(1'b1, 1'b0);
        wait_n(5);
        begin
            int k0 = n_ka;
            int r0 = n_rst;
            se0(80, 1'b1, 1'b0);
            check("R7 no keep-alive in mode 2", n_ka - k0, 0);
            check("R8 mode 2 kept", speed_mode, 2);
            se0(130, 1'b1, 1'b0);
            check("R6 reset from mode 2", n_rst - r0, 1);
            check("R6 back to forced low", speed_mode, 1);
        end
    endtask

    task automatic t_forced_full();
        start(2'd1, 1'b0, 1'b1);
        check("R8 forced full ignores level", speed_mode, 0);
        check("R2 K forced full", sym_code, 2);
        se0(30, 1'b0, 1'b1);
        check("R8 forced full kept", speed_mode, 0);
    endtask

    bit done = 1'b0;

    initial begin
        t_auto_full();
        t_auto_low();
        t_keepalive();
        t_reset_relearn();
        t_forced_low();
        t_forced_full();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule